// File: doc/BRIEF.md
# Offset-Encoded Reference Clock Divider

This block produces a slower clock from a reference clock. The division ratio is set by a 7-bit field held in the low bits of an 8-bit configuration byte. The hardware always adds a fixed two to that field. A stored zero therefore still halves the reference, and the largest field value gives a ratio of 129. The top bit of the same byte drives a neighbouring feedback-divider control, and this block ignores it.

Each output period starts with the divided clock high. The block also raises a strobe for one reference cycle in the last cycle of every period, which a phase-detector model can use.

A ratio written to the byte in the middle of a period is not used at once. It is taken in only at the period boundary, so the output never shows a shortened high or low phase. After reset the block loads the field at the first reference edge and starts a fresh period.

Top module: `refclk_ratio_div`

## Requirements
- R1: The output period, in reference cycles, equals the value of cfg_byte bits 6..0 plus 2, sampled at the edge that starts the period.
- R2: A field value of 0 gives a period of 2 reference cycles: one cycle high, one cycle low.
- R3: A field value of 127 gives a period of 129 reference cycles.
- R4: Bit 7 of cfg_byte has no effect on the output or on the strobe.
- R5: For an even ratio N, the output is high for N/2 cycles and then low for N/2 cycles.
- R6: For an odd ratio N, the output is high for floor(N/2) cycles and then low for the remaining cycles.
- R7: tc_pulse_o is high for exactly one reference cycle per period, in the last cycle of the period. In the next cycle the output is high at the start of a new period.
- R8: A change of the field during a period leaves that period unchanged. The new value applies from the next period boundary.
- R9: While rst_n is low, clk_div_o and tc_pulse_o are low. At the first rising edge after release, the block loads the field and starts a period with the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Configuration byte; bits 6..0 hold the ratio field, bit 7 is not used here |
| clk_div_o | output | 1 | Divided clock |
| tc_pulse_o | output | 1 | One-cycle strobe in the last cycle of each period |

## Verification
The hardest case to reach from the ports is a field change that lands in the middle of a long period, followed by more changes before the boundary. In that case only the value present at the boundary edge may take effect.

The stimulus handles this in three ways:
- It holds the field at 127 and then switches it partway through the 129-cycle period.
- It runs a stretch where the field and bit 7 are re-randomised on every cycle.
- It applies a reset in the middle of a period.

The scoreboard model tracks the period phase and takes the field only at boundaries. Any early reload therefore shows up as a mismatch in the output or the strobe.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  localparam int RD_FIELD_W = 7;
  localparam int RD_OFFSET  = 2;
  localparam int RD_MAX_RATIO = (1 << RD_FIELD_W) - 1 + RD_OFFSET;
  localparam int RD_RATIO_W = $clog2(RD_MAX_RATIO + 1);

  typedef logic [RD_FIELD_W-1:0] field_t;
  typedef logic [RD_RATIO_W-1:0] ratio_t;

  // Total division ratio for a stored field value.
  function automatic ratio_t tot_ratio(input field_t f);
    return ratio_t'(f) + ratio_t'(RD_OFFSET);
  endfunction

  // Number of high cycles in one output period.
  function automatic ratio_t high_span(input ratio_t r);
    return r >> 1;
  endfunction

  // Count value of the last cycle in a period.
  function automatic ratio_t last_count(input ratio_t r);
    return r - ratio_t'(1);
  endfunction
endpackage

// File: rtl/rdiv_field_hold.sv
module rdiv_field_hold
  import rdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wrap_i,
  input  field_t field_i,
  output ratio_t ratio_o,
  output ratio_t ratio_nxt_o
);
  ratio_t ratio_q;

  // The new ratio is visible one edge early so that the output stage can
  // look ahead when a period starts.
  always_comb begin
    ratio_nxt_o = wrap_i ? tot_ratio(field_i) : ratio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ratio_q <= tot_ratio('0);
    else        ratio_q <= ratio_nxt_o;
  end

  assign ratio_o = ratio_q;
endmodule

// File: rtl/rdiv_phase_ctr.sv
module rdiv_phase_ctr
  import rdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_i,
  output ratio_t cnt_o,
  output ratio_t cnt_nxt_o,
  output logic   wrap_o,
  output logic   tc_o
);
  ratio_t cnt_q;
  logic   fresh_q;
  logic   at_last;

  assign at_last = (cnt_q == last_count(ratio_i));

  // A period boundary happens in the last cycle, and also once straight
  // after reset so that the field is loaded at the first edge.
  assign wrap_o = fresh_q | at_last;
  assign tc_o   = at_last & ~fresh_q;

  always_comb begin
    cnt_nxt_o = wrap_o ? '0 : cnt_q + ratio_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt_o;
      fresh_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rdiv_wave_gen.sv
module rdiv_wave_gen
  import rdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t cnt_nxt_i,
  input  ratio_t ratio_nxt_i,
  output logic   wave_o
);
  logic wave_q;

  // The level is registered from next-state values, so the output leaves
  // a flop directly and carries no glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= (cnt_nxt_i < high_span(ratio_nxt_i));
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/refclk_ratio_div.sv
module refclk_ratio_div
  import rdiv_pkg::*;
(
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [7:0] cfg_byte,
  output logic       clk_div_o,
  output logic       tc_pulse_o
);
  // Named internal events used by the bound checker.
  ratio_t ratio_act;
  ratio_t ratio_nxt;
  ratio_t cnt;
  ratio_t cnt_nxt;
  logic   wrap;
  field_t field;

  // Only the low field bits reach the divider; bit 7 belongs elsewhere.
  assign field = cfg_byte[RD_FIELD_W-1:0];

  rdiv_field_hold u_hold (
    .clk         (clk_ref),
    .rst_n       (rst_n),
    .wrap_i      (wrap),
    .field_i     (field),
    .ratio_o     (ratio_act),
    .ratio_nxt_o (ratio_nxt)
  );

  rdiv_phase_ctr u_ctr (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .ratio_i   (ratio_act),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap),
    .tc_o      (tc_pulse_o)
  );

  rdiv_wave_gen u_wave (
    .clk         (clk_ref),
    .rst_n       (rst_n),
    .cnt_nxt_i   (cnt_nxt),
    .ratio_nxt_i (ratio_nxt),
    .wave_o      (clk_div_o)
  );
endmodule

// File: rtl/refclk_ratio_div_chk.sv
module refclk_ratio_div_chk
  import rdiv_pkg::*;
(
  input logic       clk_ref,
  input logic       rst_n,
  input logic [7:0] cfg_byte,
  input logic       clk_div_o,
  input logic       tc_pulse_o,
  input ratio_t     ratio_act,
  input ratio_t     cnt,
  input logic       wrap
);
  // R1: a boundary loads the sampled field plus the offset
  assert_ratio_load_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    wrap |=> (int'(ratio_act) == int'($past(cfg_byte[RD_FIELD_W-1:0])) + RD_OFFSET));

  // R1: the counter never reaches the active ratio
  assert_cnt_range_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt < ratio_act);

  // R8: the active ratio stays fixed between boundaries
  assert_ratio_hold_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !wrap |=> $stable(ratio_act));

  // R7: the strobe lasts exactly one cycle
  assert_tc_single_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tc_pulse_o |=> !tc_pulse_o);

  // R7: a strobe is followed by a new period that starts high
  assert_tc_restart_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tc_pulse_o |=> (clk_div_o && cnt == '0));

  // R5: the output rises only at the start of a period
  assert_rise_at_start_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_div_o) |-> (cnt == '0));

  // R9: outputs are quiet while reset is held
  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!clk_div_o && !tc_pulse_o);
    end
  end
endmodule

bind refclk_ratio_div refclk_ratio_div_chk i_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .cfg_byte   (cfg_byte),
  .clk_div_o  (clk_div_o),
  .tc_pulse_o (tc_pulse_o),
  .ratio_act  (ratio_act),
  .cnt        (cnt),
  .wrap       (wrap)
);

// File: tb/test_refclk_ratio_div.sv
module test_refclk_ratio_div;
  localparam int CLK_PER = 10;
  localparam int WATCHDOG_CYC = 150000;

  typedef struct {
    bit    out;
    bit    tc;
    string tag;
  } exp_t;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic       clk_div_o;
  logic       tc_pulse_o;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  // Reference model state, kept separately from the design.
  bit started = 1'b0;
  int phase   = 0;
  int period  = 2;

  refclk_ratio_div i_refclk_ratio_div (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .cfg_byte   (cfg_byte),
    .clk_div_o  (clk_div_o),
    .tc_pulse_o (tc_pulse_o)
  );

  always #(CLK_PER/2) clk_ref = ~clk_ref;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Entered and left at a negedge. Holds reset, checks quiet outputs (R9).
  task automatic do_reset(input int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_ref);
      check(clk_div_o == 1'b0, "R9", "clk_div_o in reset", int'(clk_div_o), 0);
      check(tc_pulse_o == 1'b0, "R9", "tc_pulse_o in reset", int'(tc_pulse_o), 0);
    end
    rst_n   = 1'b1;
    started = 1'b0;
  endtask

  // Driver: entered at a negedge. Each cycle it sets cfg, updates the model
  // for the coming edge, pushes the expectation and moves to the next negedge.
  // mode 0: fixed byte; 1: bit 7 toggles; 2: random byte every cycle.
  task automatic drive(input logic [7:0] base, input int cycles,
                       input int mode, input string tag);
    exp_t e;
    for (int i = 0; i < cycles; i++) begin
      case (mode)
        1:       cfg_byte = {base[7] ^ i[0], base[6:0]};
        2:       cfg_byte = 8'($urandom);
        default: cfg_byte = base;
      endcase
      if (!started || phase == period - 1) begin
        period  = int'(cfg_byte[6:0]) + 2;
        phase   = 0;
        started = 1'b1;
      end else begin
        phase++;
      end
      e.out = (phase < period / 2);
      e.tc  = (phase == period - 1);
      e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk_ref);
    end
  endtask

  // Monitor: compares a quarter period after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_ref);
      #(CLK_PER/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(clk_div_o == e.out, e.tag, "clk_div_o", int'(clk_div_o), int'(e.out));
        check(tc_pulse_o == e.tc, e.tag, "tc_pulse_o", int'(tc_pulse_o), int'(e.tc));
      end
    end
  end

  initial begin
    @(negedge clk_ref);
    do_reset(3);
    drive(8'h00, 20, 0, "R2");      // ratio 2
    drive(8'h80, 20, 1, "R4");      // ratio 2, bit 7 toggling
    drive(8'h02, 40, 0, "R5");      // ratio 4
    drive(8'h04, 48, 1, "R4");      // ratio 6, bit 7 toggling
    drive(8'h01, 30, 0, "R6");      // ratio 3
    drive(8'h07, 45, 0, "R6");      // ratio 9
    drive(8'h0A, 60, 0, "R1");      // ratio 12
    drive(8'h7F, 40, 0, "R3");      // ratio 129, then a change mid-period
    drive(8'h03, 300, 0, "R8");
    drive(8'hFF, 270, 1, "R3");     // ratio 129, bit 7 toggling
    drive(8'h05, 400, 2, "R8");     // field randomised every cycle
    drive(8'h06, 12, 0, "R7");      // ratio 8, then reset mid-period
    do_reset(2);
    drive(8'h0B, 60, 0, "R9");      // ratio 13 directly after reset
    drive(8'h00, 10, 0, "R7");
    @(negedge clk_ref);
    @(negedge clk_ref);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk_ref);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYC, 0);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule